// File: doc/BRIEF.md
# GPIO controller with edge-detect interrupts

This block is a general-purpose I/O port of 28 pins sitting on a simple word-wide register bus. Software picks each pin's direction and drives output levels by writing to a set word or a clear word. Because only the bits written as 1 change, no read-modify-write sequence is ever needed. The synchronized level of every pin can be read back at any time, whatever the pin's direction.

Each pin can flag rising edges, falling edges or both, and each sense has its own enable. A detected edge is held in a status word until software writes 1 to that bit. The status word drives the interrupt outputs. Each of the eleven lowest pins has a private interrupt line. The seventeen upper pins share one line, which is the OR of their status bits. A spare word of plain storage is provided for pin-function selection, which other logic may decode.

Registers are 32-bit words at byte offsets. Address bits [4:2] pick the register and bits [1:0] are ignored. The offsets are: 0x00 pin level (read-only), 0x04 direction, 0x08 output set, 0x0C output clear, 0x10 rising enable, 0x14 falling enable, 0x18 edge status, 0x1C function-select storage. Pin n is bit n of every word. Bits 31:28 read as zero.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Each register sits at its fixed byte offset listed above and is selected by address bits [4:2]; a value written to the direction, rising-enable, falling-enable or function-select word reads back at that same offset, with bits 31:28 reading 0.
- R2: A direction bit of 1 makes the pin an output: `pin_oe[n]` follows direction bit n from the clock edge that captures the write.
- R3: Writing a word to offset 0x08 drives `pin_out[n]` high for every bit n written as 1 and leaves the other bits unchanged.
- R4: Writing a word to offset 0x0C drives `pin_out[n]` low for every bit n written as 1 and leaves the other bits unchanged.
- R5: Offset 0x00 returns the pin inputs after a two-flop synchronizer, whatever the direction: a change made before clock edge k reads back after edge k+1 and not after edge k. Writes to 0x00 change nothing.
- R6: With its rising enable set, a 0-to-1 change on pin n sets status bit n after clock edge k+2. With its falling enable set, a 1-to-0 change does the same. A change of a sense that is not enabled sets nothing.
- R7: Writing 1 to a status bit at 0x18 clears it; writing 0 leaves it unchanged, and a status bit never clears without such a write.
- R8: When a new edge and a write of 1 reach the same status bit in the same cycle, the bit stays set.
- R9: `irq_pin[n]` for n in 0..10 equals status bit n.
- R10: `irq_shared` is the OR of status bits 11 to 27.
- R11: After reset every pin is an input, the output latch, both enable words, the status word and the function-select word are zero, and all interrupt lines are low.
- R12: The set and clear words at 0x08 and 0x0C always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 28 | Asynchronous pin levels |
| pin_out | output | 28 | Output latch value |
| pin_oe | output | 28 | Output enable per pin (direction word) |
| irq_pin | output | 11 | Private interrupts of pins 0 to 10 |
| irq_shared | output | 1 | Shared interrupt of pins 11 to 27 |

## Verification
A wrong status bit shows on an interrupt line in the same cycle, so a lost or spurious edge is visible three clock edges after the pin moves. A stale previous-level register shows the same way, as a missing edge or an extra one. A wrong output latch or direction bit shows on `pin_out` or `pin_oe` one edge after the write. A broken synchronizer shows as a level readback one cycle early or late. Random bus and pin traffic is checked against a bench model after each step, and directed sequences cover the collision between an edge and its clear, the one-cycle latency window, and the split between private and shared interrupt lines.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // Register index, taken from byte-address bits [4:2]
   typedef enum logic [2:0] {
      REG_LEVEL = 3'd0,
      REG_DIR   = 3'd1,
      REG_SET   = 3'd2,
      REG_CLR   = 3'd3,
      REG_RISE  = 3'd4,
      REG_FALL  = 3'd5,
      REG_STAT  = 3'd6,
      REG_FSEL  = 3'd7
   } gpio_reg_e;

   localparam int unsigned IDX_LSB = 2;
   localparam int unsigned IDX_W   = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int unsigned WIDTH = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] status
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] hit;

   // Compare against the previous synchronized sample
   assign hit = (rise_en & level & ~prev_q) | (fall_en & ~level & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= level;
         // a fresh edge outranks a clear in the same cycle
         status <= (status & ~clr_mask) | hit;
      end
   end
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
   parameter int unsigned WIDTH      = 28,
   parameter int unsigned NUM_DIRECT = 11
) (
   input  logic [WIDTH-1:0]      status,
   output logic [NUM_DIRECT-1:0] irq_pin,
   output logic                  irq_shared
);
   assign irq_pin = status[NUM_DIRECT-1:0];

   if (NUM_DIRECT < WIDTH) begin : g_shared
      assign irq_shared = |status[WIDTH-1:NUM_DIRECT];
   end else begin : g_no_shared
      assign irq_shared = 1'b0;
   end
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
   parameter int unsigned NUM_PINS       = 28,
   parameter int unsigned NUM_DIRECT_IRQ = 11,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 5,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      bus_wr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   input  logic [NUM_PINS-1:0]       pin_in,
   output logic [NUM_PINS-1:0]       pin_out,
   output logic [NUM_PINS-1:0]       pin_oe,
   output logic [NUM_DIRECT_IRQ-1:0] irq_pin,
   output logic                      irq_shared
);
   import gpio_edge_pkg::*;

   localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

   // Elaboration-time parameter checks
   initial begin
      if (NUM_PINS > DATA_W)
         $fatal(1, "NUM_PINS must fit the data word");
      if (NUM_DIRECT_IRQ == 0 || NUM_DIRECT_IRQ > NUM_PINS)
         $fatal(1, "NUM_DIRECT_IRQ out of range");
      if (ADDR_W < IDX_MSB + 1)
         $fatal(1, "ADDR_W too narrow for the register map");
      if (SYNC_STAGES < 2)
         $fatal(1, "SYNC_STAGES must be at least 2");
   end

   gpio_reg_e            reg_sel;
   logic [NUM_PINS-1:0]  wd;
   logic [NUM_PINS-1:0]  dir_q, out_q, rise_q, fall_q, fsel_q;
   logic [NUM_PINS-1:0]  level_sync;
   logic [NUM_PINS-1:0]  edge_status;
   logic [NUM_PINS-1:0]  stat_clr;
   logic [NUM_PINS-1:0]  rd_pins;
   logic                 unused_bits;

   assign reg_sel     = gpio_reg_e'(bus_addr[IDX_MSB:IDX_LSB]);
   assign wd          = bus_wdata[NUM_PINS-1:0];
   assign unused_bits = ^{bus_addr, bus_wdata};

   // Control words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         fsel_q <= '0;
      end else if (bus_wr) begin
         unique case (reg_sel)
            REG_DIR:  dir_q  <= wd;
            REG_SET:  out_q  <= out_q | wd;
            REG_CLR:  out_q  <= out_q & ~wd;
            REG_RISE: rise_q <= wd;
            REG_FALL: fall_q <= wd;
            REG_FSEL: fsel_q <= wd;
            default: ;
         endcase
      end
   end

   assign stat_clr = (bus_wr && reg_sel == REG_STAT) ? wd : '0;

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (level_sync)
   );

   gpio_edge_det #(
      .WIDTH (NUM_PINS)
   ) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level_sync),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .clr_mask (stat_clr),
      .status   (edge_status)
   );

   gpio_irq_map #(
      .WIDTH      (NUM_PINS),
      .NUM_DIRECT (NUM_DIRECT_IRQ)
   ) u_irq (
      .status     (edge_status),
      .irq_pin    (irq_pin),
      .irq_shared (irq_shared)
   );

   // Read path
   always_comb begin
      unique case (reg_sel)
         REG_LEVEL: rd_pins = level_sync;
         REG_DIR:   rd_pins = dir_q;
         REG_RISE:  rd_pins = rise_q;
         REG_FALL:  rd_pins = fall_q;
         REG_STAT:  rd_pins = edge_status;
         REG_FSEL:  rd_pins = fsel_q;
         default:   rd_pins = '0;
      endcase
   end

   if (NUM_PINS < DATA_W) begin : g_rd_pad
      assign bus_rdata = {{(DATA_W-NUM_PINS){1'b0}}, rd_pins};
   end else begin : g_rd_full
      assign bus_rdata = rd_pins;
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
   parameter int unsigned NUM_PINS       = 28,
   parameter int unsigned NUM_DIRECT_IRQ = 11,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned ADDR_W         = 5
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic                      bus_wr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [DATA_W-1:0]         bus_rdata,
   input logic [NUM_PINS-1:0]       pin_out,
   input logic [NUM_PINS-1:0]       pin_oe,
   input logic [NUM_DIRECT_IRQ-1:0] irq_pin,
   input logic                      irq_shared,
   input logic [NUM_PINS-1:0]       status,
   input logic [NUM_PINS-1:0]       rise_en,
   input logic [NUM_PINS-1:0]       fall_en
);
   import gpio_edge_pkg::*;

   logic [2:0]          sel;
   logic [NUM_PINS-1:0] wd;
   assign sel = bus_addr[4:2];
   assign wd  = bus_wdata[NUM_PINS-1:0];

   // R7: a status bit never drops without a status write
   p_no_silent_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel == REG_STAT) |=> ((status & $past(status)) == $past(status)));

   // R6: new status bits only on pins with some edge enabled
   p_edge_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

   // R3: set word raises every written-one bit
   p_set_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == REG_SET) |=> ((pin_out & $past(wd)) == $past(wd)));

   // R4: clear word lowers every written-one bit
   p_clr_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == REG_CLR) |=> ((pin_out & $past(wd)) == '0));

   // R2: output enables match the readable direction word
   p_oe_matches_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_DIR) |-> (pin_oe == bus_rdata[NUM_PINS-1:0]));

   // R9: private lines match the readable status word
   p_irq_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_STAT) |-> (irq_pin == bus_rdata[NUM_DIRECT_IRQ-1:0]));

   // R10: shared line matches the upper status bits read over the bus
   p_irq_shared_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_STAT) |-> (irq_shared == (|bus_rdata[NUM_PINS-1:NUM_DIRECT_IRQ])));

   // R12: set and clear words read zero
   p_setclr_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_SET || sel == REG_CLR) |-> (bus_rdata == '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
   .NUM_PINS       (NUM_PINS),
   .NUM_DIRECT_IRQ (NUM_DIRECT_IRQ),
   .DATA_W         (DATA_W),
   .ADDR_W         (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq_pin    (irq_pin),
   .irq_shared (irq_shared),
   .status     (edge_status),
   .rise_en    (rise_q),
   .fall_en    (fall_q)
);

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;
   localparam int NP = 28;
   localparam int ND = 11;
   localparam logic [31:0] PMASK = 32'h0FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic [ND-1:0] irq_pin;
   logic          irq_shared;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // bench model
   logic [31:0] m_dir = 0, m_out = 0, m_rise = 0, m_fall = 0, m_stat = 0, m_fsel = 0;

   always #5 clk = ~clk;

   gpio_edge_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin(irq_pin), .irq_shared(irq_shared)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_reg(input int idx);
      case (idx)
         0: return {4'b0, pin_in};
         1: return m_dir;
         4: return m_rise;
         5: return m_fall;
         6: return m_stat;
         7: return m_fsel;
         default: return 32'h0;
      endcase
   endfunction

   task automatic bus_write(input int idx, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 5'(idx * 4); bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      case (idx)
         1: m_dir  = d & PMASK;
         2: m_out  = m_out | (d & PMASK);
         3: m_out  = m_out & ~d;
         4: m_rise = d & PMASK;
         5: m_fall = d & PMASK;
         6: m_stat = m_stat & ~d;
         7: m_fsel = d & PMASK;
         default: ;
      endcase
   endtask

   task automatic bus_read(input int idx, output logic [31:0] v);
      @(negedge clk);
      bus_addr = 5'(idx * 4); bus_wr = 1'b0;
      #1 v = bus_rdata;
   endtask

   task automatic drive_pins(input logic [NP-1:0] nv);
      logic [31:0] o, n;
      o = {4'b0, pin_in}; n = {4'b0, nv};
      @(negedge clk);
      pin_in = nv;
      repeat (4) @(negedge clk);
      m_stat = m_stat | (m_rise & ~o & n) | (m_fall & o & ~n);
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      for (int i = 0; i < 8; i++) begin
         bus_read(i, v);
         chk($sformatf("%s reg%0d", tag, i), v, exp_reg(i));
      end
      chk({tag, " R3/R4 pin_out"}, {4'b0, pin_out}, m_out);
      chk({tag, " R2 pin_oe"}, {4'b0, pin_oe}, m_dir);
      chk({tag, " R9 irq_pin"}, {21'b0, irq_pin}, m_stat & 32'h7FF);
      chk({tag, " R10 irq_shared"}, {31'b0, irq_shared}, {31'b0, |m_stat[27:11]});
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      check_all("R11 reset");

      // R1: offsets read back what was written
      bus_write(1, 32'hFFFF_0000);
      bus_write(4, 32'h0000_0A5A);
      bus_write(5, 32'h0123_4000);
      bus_write(7, 32'hFEDC_BA98);
      check_all("R1 map");
      bus_write(1, 0); bus_write(4, 0); bus_write(5, 0);

      // R3/R4 set and clear
      bus_write(2, 32'h0000_0005);
      bus_write(2, 32'h0000_0030);
      chk("R3 set merge", {4'b0, pin_out}, 32'h35);
      bus_write(3, 32'h0000_0001);
      chk("R4 clear one bit", {4'b0, pin_out}, 32'h34);
      bus_write(3, 32'h0);
      chk("R4 zero clear no effect", {4'b0, pin_out}, 32'h34);

      // R12: set/clear read zero
      bus_read(2, v); chk("R12 set reads 0", v, 0);
      bus_read(3, v); chk("R12 clr reads 0", v, 0);

      // R5: latency and direction independence
      bus_write(1, PMASK);
      bus_read(0, v);
      @(negedge clk); pin_in = 28'h00A_5A5A; bus_addr = 5'h00;
      @(negedge clk); #1 chk("R5 level not yet", bus_rdata, 0);
      @(negedge clk); #1 chk("R5 level after two edges", bus_rdata, 32'h00A_5A5A);
      bus_write(0, 32'hFFFF_FFFF);
      bus_read(0, v); chk("R5 level write ignored", v, 32'h00A_5A5A);
      drive_pins('0);
      bus_write(1, 0);

      // R6: independent senses
      bus_write(4, 32'h0000_0028);          // rise on pins 3,5
      bus_write(5, 32'h0000_1020);          // fall on pins 12,5
      drive_pins(28'h0000_1028);
      chk("R6 rising sets 3,5", m_stat, 32'h28);
      check_all("R6 rise");
      drive_pins(28'h0000_0000);
      check_all("R6 fall");

      // R7: write 0 vs write 1
      bus_write(6, 32'h0);
      check_all("R7 zero write");
      bus_write(6, 32'h0000_0008);
      check_all("R7 clear bit3");

      // R8: collision, pin 2 rises while status 2 and 4 are cleared
      bus_write(6, PMASK);
      bus_write(4, 32'h0000_0014);
      bus_write(5, 32'h0);
      drive_pins(28'h0000_0014);            // sets 2,4
      drive_pins(28'h0000_0010);            // drop pin 2, no fall enable
      @(negedge clk); pin_in = 28'h0000_0014;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      bus_addr = 5'h18; bus_wr = 1'b1; bus_wdata = 32'h14;
      @(negedge clk); bus_wr = 1'b0;
      m_stat = 32'h0000_0004;
      repeat (3) @(negedge clk);
      check_all("R8 edge wins");

      // R9/R10: private vs shared lines
      bus_write(6, PMASK);
      bus_write(4, 32'h0800_0400);          // pins 27 and 10
      drive_pins(28'h0800_0400);
      check_all("R9 R10 split");
      bus_write(6, 32'h0000_0400);
      check_all("R10 shared only");

      // random traffic
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 3);
         if (op == 0) bus_write(int'($urandom % 8), $urandom);
         else if (op == 1) drive_pins(NP'($urandom));
         else check_all("R1-rand R6 R7 R12");
      end
      check_all("R6 R7 final");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule